// File: doc/BRIEF.md
# Topology ID Bucketing Unit

This block sorts a stream of logical-processor identifiers into physical-core groups. Each input beat carries two identifier fields, a package field and a core field, still at their original bit positions. The block merges the two fields with a bitwise OR to form a grouping key. Processors whose keys are equal are treated as threads of the same physical core. The same field layout is assumed in every package, so processors from different packages are compared against one shared set of keys.

Every accepted beat has an arrival position: 0 for the first beat after a start, then 1, 2 and so on. Each group keeps its key as a tag, together with a membership mask in which bit n marks the processor at position n. A running count gives the number of distinct groups. Software or a sequencer pulses the start input, streams one identifier per valid beat, and flags the final one with the last marker. It then reads the count, tags and masks when the done pulse appears. Beats beyond capacity are discarded and a sticky overflow flag is raised.

Top module: `topo_bucket`

## Requirements
- R1: The grouping key of a beat is pkg_id_i | core_id_i, with no shifting. Two beats whose ORed keys are equal land in the same group, even when their separate fields differ.
- R2: The first accepted beat after reset or start opens group 0. Its tag is that beat's key, its mask is 1 (only bit 0 set), and count_o becomes 1.
- R3: The accepted beat at arrival position n, counting from 0 after start, contributes mask bit n and no other bit.
- R4: When a beat's key matches an existing group, its bit is ORed into the mask of the lowest-index matching group. No other group changes, and count_o stays the same.
- R5: When a beat's key matches no existing group, a new group is created at index count_o, holding the key as its tag and the beat's bit as its mask, and count_o rises by one.
- R6: Groups at an index at or above count_o read a tag of 0 and a mask of 0.
- R7: A cycle with start_i high clears all groups, count_o, overflow_o and the arrival position. A valid beat presented in that same cycle is ignored.
- R8: done_o is high for exactly the one cycle after the clock edge that consumes a valid beat with last_i set. This also applies when that beat is dropped. At all other times done_o is low.
- R9: A beat is dropped when NPROC beats have already been accepted since start, or when its key is new and all NBKT groups are in use. A dropped beat leaves the groups, count_o and the arrival position unchanged, and it sets overflow_o, which stays high until start or reset.
- R10: After reset, count_o, overflow_o and done_o are 0, and every tag and mask is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the table and begins a new run |
| valid_i | input | 1 | An identifier beat is present |
| last_i | input | 1 | Marks the final beat of the run |
| pkg_id_i | input | ID_W (8) | Package identifier field, unshifted |
| core_id_i | input | ID_W (8) | Core identifier field, unshifted |
| done_o | output | 1 | One-cycle pulse after the last beat is consumed |
| overflow_o | output | 1 | Sticky: at least one beat was dropped |
| count_o | output | $clog2(NBKT+1) (5) | Number of groups in use |
| tags_o | output | NBKT*ID_W (128) | Group tags; group b at [b*ID_W +: ID_W] |
| masks_o | output | NBKT*NPROC (256) | Group masks; group b at [b*NPROC +: NPROC] |

## Verification
Each beat is folded into the table at the clock edge that samples it. The count, tags, masks and overflow flag therefore already show the final state when done_o rises, one cycle after the last beat is presented. The driver computes the expected table with its own model and queues it when it presents a last beat. The monitor samples on the falling edge and pops one queued entry for every done pulse it sees, so every comparison lands in the cycle in which done_o is high. Clearing on start and the reset state are checked at the falling edge one cycle after the start or reset edge.

// File: rtl/topo_pkg.sv
package topo_pkg;
  localparam int ID_W = 8;
  typedef logic [ID_W-1:0] topo_id_t;

  // Grouping key: fields already sit at their own positions, so OR merges them
  function automatic topo_id_t merge_key(topo_id_t pkg, topo_id_t core);
    return pkg | core;
  endfunction
endpackage

// File: rtl/bucket_match.sv
module bucket_match #(
  parameter int NBKT  = 16,
  parameter int KEY_W = 8,
  localparam int IDX_W = (NBKT > 1) ? $clog2(NBKT) : 1
) (
  input  logic [KEY_W-1:0]      key_i,
  input  logic [NBKT*KEY_W-1:0] tags_i,
  input  logic [NBKT-1:0]       used_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      hit_idx_o
);
  logic [NBKT-1:0] eq_vec;

  // Parallel compare against every group in use
  for (genvar b = 0; b < NBKT; b++) begin : g_cmp
    assign eq_vec[b] = used_i[b] && (tags_i[b*KEY_W +: KEY_W] == key_i);
  end

  // Priority pick: lowest index wins (loop descends so the lowest overrides)
  always_comb begin
    hit_idx_o = '0;
    for (int b = NBKT - 1; b >= 0; b--) begin
      if (eq_vec[b]) hit_idx_o = IDX_W'(b);
    end
  end

  assign hit_o = |eq_vec;
endmodule

// File: rtl/bucket_store.sv
module bucket_store #(
  parameter int NBKT  = 16,
  parameter int NPROC = 16,
  parameter int KEY_W = 8,
  localparam int IDX_W = (NBKT > 1) ? $clog2(NBKT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic                   join_i,
  input  logic                   open_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [KEY_W-1:0]       key_i,
  input  logic [NPROC-1:0]       bit_i,
  output logic [NBKT*KEY_W-1:0]  tags_o,
  output logic [NBKT*NPROC-1:0]  masks_o,
  output logic [NBKT-1:0]        used_o
);
  logic [NBKT-1:0] join_sel;
  logic [NBKT-1:0] open_sel;

  for (genvar b = 0; b < NBKT; b++) begin : g_slot
    logic [KEY_W-1:0] tag_q;
    logic [NPROC-1:0] mask_q;
    logic             used_q;

    assign join_sel[b] = join_i && (idx_i == IDX_W'(b));
    assign open_sel[b] = open_i && (idx_i == IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        mask_q <= '0;
        used_q <= 1'b0;
      end else if (clr_i) begin
        tag_q  <= '0;
        mask_q <= '0;
        used_q <= 1'b0;
      end else if (open_sel[b]) begin
        tag_q  <= key_i;
        mask_q <= bit_i;
        used_q <= 1'b1;
      end else if (join_sel[b]) begin
        mask_q <= mask_q | bit_i;
      end
    end

    assign tags_o[b*KEY_W +: KEY_W]   = tag_q;
    assign masks_o[b*NPROC +: NPROC]  = mask_q;
    assign used_o[b]                  = used_q;

    // R6: a slot not in use holds an empty mask
    a_r6_unused_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !used_q |-> (mask_q == '0));
  end

  // R4: a beat updates at most one group
  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(join_sel | open_sel));
endmodule

// File: rtl/topo_bucket.sv
module topo_bucket
  import topo_pkg::*;
#(
  parameter int NPROC = 16,
  parameter int NBKT  = 16,
  localparam int KEY_W  = ID_W,
  localparam int IDX_W  = (NBKT > 1) ? $clog2(NBKT) : 1,
  localparam int CNT_W  = $clog2(NBKT + 1),
  localparam int POS_W  = $clog2(NPROC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   valid_i,
  input  logic                   last_i,
  input  logic [ID_W-1:0]        pkg_id_i,
  input  logic [ID_W-1:0]        core_id_i,
  output logic                   done_o,
  output logic                   overflow_o,
  output logic [CNT_W-1:0]       count_o,
  output logic [NBKT*KEY_W-1:0]  tags_o,
  output logic [NBKT*NPROC-1:0]  masks_o
);
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             done_q;

  // Named internal events
  logic             beat_in;
  logic             procs_full;
  logic             table_full;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             drop_ev;
  logic             join_ev;
  logic             open_ev;
  logic [KEY_W-1:0] key;
  logic [NPROC-1:0] pos_bit;
  logic [IDX_W-1:0] tgt_idx;
  logic [NBKT-1:0]  used;

  assign key        = merge_key(pkg_id_i, core_id_i);
  assign beat_in    = valid_i && !start_i;
  assign procs_full = (pos_q == POS_W'(NPROC));
  assign table_full = (cnt_q == CNT_W'(NBKT));
  assign drop_ev    = beat_in && (procs_full || (!hit && table_full));
  assign join_ev    = beat_in && !procs_full && hit;
  assign open_ev    = beat_in && !procs_full && !hit && !table_full;
  assign pos_bit    = NPROC'(1) << pos_q;
  assign tgt_idx    = hit ? hit_idx : cnt_q[IDX_W-1:0];

  bucket_match #(.NBKT(NBKT), .KEY_W(KEY_W)) u_match (
    .key_i     (key),
    .tags_i    (tags_o),
    .used_i    (used),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  bucket_store #(.NBKT(NBKT), .NPROC(NPROC), .KEY_W(KEY_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .join_i  (join_ev),
    .open_i  (open_ev),
    .idx_i   (tgt_idx),
    .key_i   (key),
    .bit_i   (pos_bit),
    .tags_o  (tags_o),
    .masks_o (masks_o),
    .used_o  (used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= beat_in && last_i;
      if (start_i) begin
        pos_q <= '0;
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else begin
        if (join_ev || open_ev) pos_q <= pos_q + 1'b1;
        if (open_ev)            cnt_q <= cnt_q + 1'b1;
        if (drop_ev)            ovf_q <= 1'b1;
      end
    end
  end

  assign done_o     = done_q;
  assign overflow_o = ovf_q;
  assign count_o    = cnt_q;

  // R2: first beat of a run lands in group 0 with bit 0
  a_r2_first_group: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_in && pos_q == '0) |=> (count_o == CNT_W'(1) && masks_o[NPROC-1:0] == NPROC'(1)));
  // R5: count grows by at most one per beat
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));
  // R7: start empties the table
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == '0 && !overflow_o && masks_o == '0));
  // R8: done only follows a consumed last beat
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(valid_i && last_i && !start_i));
  // R9: overflow stays set until start
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !start_i) |=> overflow_o);
  // R9: a dropped beat leaves the table untouched
  a_r9_drop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> ($stable(masks_o) && $stable(count_o)));
endmodule

// File: tb/tb_topo_bucket.sv
module tb_topo_bucket;
  localparam int NPROC = 16;
  localparam int NBKT  = 16;
  localparam int ID_W  = 8;
  localparam int CNT_W = $clog2(NBKT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [ID_W-1:0] pkg_id_i = '0, core_id_i = '0;
  logic done_o, overflow_o;
  logic [CNT_W-1:0] count_o;
  logic [NBKT*ID_W-1:0]  tags_o;
  logic [NBKT*NPROC-1:0] masks_o;

  always #4 clk = ~clk; // 125 MHz

  topo_bucket #(.NPROC(NPROC), .NBKT(NBKT)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i), .last_i(last_i),
    .pkg_id_i(pkg_id_i), .core_id_i(core_id_i), .done_o(done_o), .overflow_o(overflow_o),
    .count_o(count_o), .tags_o(tags_o), .masks_o(masks_o));

  typedef struct {
    int                    cnt;
    bit                    ovf;
    logic [NBKT*ID_W-1:0]  tags;
    logic [NBKT*NPROC-1:0] masks;
  } snap_t;

  snap_t exp_q[$];
  int n_chk = 0, n_fail = 0;

  // Independent model state
  logic [ID_W-1:0]  m_tag[NBKT];
  logic [NPROC-1:0] m_mask[NBKT];
  int m_cnt, m_pos;
  bit m_ovf;

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int b = 0; b < NBKT; b++) begin m_tag[b] = '0; m_mask[b] = '0; end
    m_cnt = 0; m_pos = 0; m_ovf = 0;
  endtask

  function automatic snap_t model_snap();
    snap_t s;
    s.cnt = m_cnt; s.ovf = m_ovf; s.tags = '0; s.masks = '0;
    for (int b = 0; b < NBKT; b++) begin
      s.tags[b*ID_W +: ID_W]    = m_tag[b];
      s.masks[b*NPROC +: NPROC] = m_mask[b];
    end
    return s;
  endfunction

  // R1, R3, R4, R5, R9 restated as a sequential search
  task automatic model_beat(logic [ID_W-1:0] p, logic [ID_W-1:0] c);
    logic [ID_W-1:0] k;
    int found;
    k = p | c;
    found = -1;
    if (m_pos >= NPROC) begin m_ovf = 1; return; end
    for (int b = 0; b < m_cnt; b++)
      if (found < 0 && m_tag[b] == k) found = b;
    if (found >= 0) begin
      m_mask[found][m_pos] = 1'b1;
      m_pos++;
    end else if (m_cnt == NBKT) begin
      m_ovf = 1;
    end else begin
      m_tag[m_cnt] = k;
      m_mask[m_cnt] = '0;
      m_mask[m_cnt][m_pos] = 1'b1;
      m_cnt++;
      m_pos++;
    end
  endtask

  task automatic beat(logic [ID_W-1:0] p, logic [ID_W-1:0] c, bit last);
    valid_i = 1'b1; last_i = last; pkg_id_i = p; core_id_i = c;
    model_beat(p, c);
    if (last) exp_q.push_back(model_snap());
    @(negedge clk);
    valid_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic start_run();
    start_i = 1'b1;
    model_clear();
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: one expected snapshot per done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected done", 1, 0);
      end else begin
        snap_t e;
        e = exp_q.pop_front();
        chk(count_o == CNT_W'(e.cnt), "R2/R5 count", 256'(count_o), 256'(e.cnt));
        chk(overflow_o == e.ovf, "R9 overflow", 256'(overflow_o), 256'(e.ovf));
        chk(tags_o == e.tags, "R1/R5/R6 tags", 256'(tags_o), 256'(e.tags));
        chk(masks_o == e.masks, "R3/R4/R6 masks", masks_o, e.masks);
      end
    end
  end

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(count_o == '0, "R10 count", 256'(count_o), 0);
    chk(!done_o && !overflow_o, "R10 flags", {done_o, overflow_o}, 0);
    chk(masks_o == '0 && tags_o == '0, "R10 table", masks_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R4/R5: 0x10|0x01 and 0x00|0x11 share a key
    start_run();
    beat(8'h10, 8'h01, 0);
    beat(8'h10, 8'h02, 0);
    beat(8'h00, 8'h11, 0);
    beat(8'h20, 8'h01, 0);
    beat(8'h10, 8'h02, 1);
    @(negedge clk);
    chk(!done_o, "R8 single-cycle done", 256'(done_o), 0);

    // R7: start with a simultaneous valid beat ignores the beat
    start_i = 1'b1; valid_i = 1'b1; pkg_id_i = 8'h33; last_i = 1'b1;
    model_clear();
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0; last_i = 1'b0;
    chk(count_o == '0 && masks_o == '0, "R7 clear", 256'(count_o), 0);
    chk(!done_o, "R7 beat ignored no done", 256'(done_o), 0);

    // R3: all distinct keys, 16 groups, one bit each
    for (int i = 0; i < NPROC; i++) beat(8'(i << 4), 8'(i), i == NPROC - 1);
    @(negedge clk);
    // R9: one more beat is dropped; last on a dropped beat still gives done
    beat(8'h00, 8'h00, 1);
    @(negedge clk);

    // R7: start clears overflow
    start_run();
    chk(!overflow_o, "R7 overflow cleared", 256'(overflow_o), 0);

    // R4: all beats fold into one group
    for (int i = 0; i < NPROC; i++) beat(8'h40, 8'h04, 0);
    beat(8'h44, 8'h00, 1); // dropped: 16 already accepted (R9)
    @(negedge clk);

    // Mixed pattern, alternating two cores, back-to-back last beats
    start_run();
    beat(8'h01, 8'h00, 0);
    beat(8'h02, 8'h00, 1);
    beat(8'h00, 8'h01, 1);
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R8 missing done", 256'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule